// File: doc/BRIEF.md
# Routed Level-Interrupt Controller

This block gathers nine level-sensitive interrupt sources and steers them onto three upstream request lines. Software picks, for each line, which sources may drive it. Each line keeps a pending flag per source. A flag is latched while its source is active and enabled on that line, and software clears it by writing a one to it. A request line is high while any of its pending flags is set. For each line the block also gives the number of the highest-numbered pending source, which is the one a handler services first.

A shared configuration word sets the active level of each source. Three sources have a fixed level that this word cannot change: sources 1 and 8 are active-high and source 2 is active-low. Source inputs pass through a two-flop synchroniser before the level is applied. Software drives the block over a simple 32-bit register bus. Writes take effect on the clock edge. Reads are combinational from the current address.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every register reads 0, all request lines are low and every line's index output reads 0xF.
- R2: Address 0x0 holds the level word in bits [8:0]. Line n (n = 0..2) sits at 0x4 + 4·n, with source enables in bits [8:0] and pending flags in bits [24:16]. All other bits read 0 and ignore writes. Any other address reads 0, and a write to it changes nothing.
- R3: For sources 0 and 3–7, a level bit of 1 makes the source active when its input is high, and a level bit of 0 makes it active when its input is low.
- R4: Sources 1 and 8 are active when high and source 2 is active when low, whatever their level bits hold.
- R5: Pending flag 16+k of line n sets when source k is active and enabled on line n. It reads 1 after the third rising clock edge following the input change, and not before.
- R6: Writing 1 to pending bit 16+k clears that flag on the write edge. Writing 0 leaves it unchanged. If the source is still active and enabled, the flag sets again one edge later.
- R7: Request line n is high exactly while any pending flag of line n is set.
- R8: The 4-bit index of line n equals the highest-numbered set pending flag of that line, or 0xF when none is set.
- R9: A source that is not enabled on a line never sets that line's flags, and each line's routing is independent of the other lines.
- R10: Writing 0x01FF0000 to a line register disables every source on that line and clears all of its pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | 9 | Raw asynchronous interrupt source levels |
| irq_out | output | 3 | Upstream request lines, one per line register |
| top_idx | output | 12 | Highest pending source per line, 4 bits each, line 0 in the low nibble |

## Verification
A source change reaches its pending flag, request line and index on the third rising edge. The two synchroniser stages take two edges and the flag register takes the third. The bench therefore counts those edges and samples at the falling edge after each one. Register writes and W1C clears act on the edge of the write, so the bench reads back at the next falling edge. A clear against a source that is still active is sampled twice: once to see the flag cleared, and once more, one edge later, to see it set again. Before the register is read, the sweeps over polarity and over all 512 pending patterns let the synchroniser settle and then clear stale flags, so each read holds only flags from the pattern under test.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned SRC_N      = 9;
    localparam int unsigned LINE_N     = 3;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned CAUSE_LSB  = 16;
    localparam int unsigned IDX_W      = 4;
    localparam int unsigned CFG_ADDR   = 0;
    localparam int unsigned LINE_BASE  = 4;
    localparam int unsigned LINE_STEP  = 4;
    localparam int unsigned SYNC_DEPTH = 2;

    // Sources whose active level is fixed in hardware
    localparam logic [SRC_N-1:0] FIXED_HIGH = 9'h102;
    localparam logic [SRC_N-1:0] FIXED_LOW  = 9'h004;

    typedef enum logic [1:0] {
        LVL_PROG = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_LOW  = 2'd2
    } level_mode_e;

    function automatic level_mode_e level_mode(input logic hi_fixed, input logic lo_fixed);
        if (hi_fixed)      return LVL_HIGH;
        else if (lo_fixed) return LVL_LOW;
        else               return LVL_PROG;
    endfunction

endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond
    import irq_route_pkg::*;
#(
    parameter int unsigned      N_SRC  = SRC_N,
    parameter int unsigned      DEPTH  = SYNC_DEPTH,
    parameter logic [N_SRC-1:0] HI_FIX = FIXED_HIGH,
    parameter logic [N_SRC-1:0] LO_FIX = FIXED_LOW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_raw,
    input  logic [N_SRC-1:0] level_cfg,
    output logic [N_SRC-1:0] active
);

    logic [DEPTH-1:0][N_SRC-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= src_raw;
            for (int s = 1; s < DEPTH; s++) begin
                sync_q[s] <= sync_q[s-1];
            end
        end
    end

    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        localparam level_mode_e MODE = level_mode(HI_FIX[k], LO_FIX[k]);
        if (MODE == LVL_HIGH) begin : g_hi
            assign active[k] = sync_q[DEPTH-1][k];
        end else if (MODE == LVL_LOW) begin : g_lo
            assign active[k] = ~sync_q[DEPTH-1][k];
        end else begin : g_prog
            assign active[k] = sync_q[DEPTH-1][k] ~^ level_cfg[k];
        end
    end

    logic unused_fixed_cfg;
    assign unused_fixed_cfg = ^(level_cfg & (HI_FIX | LO_FIX));

endmodule

// File: rtl/irq_line_unit.sv
module irq_line_unit
    import irq_route_pkg::*;
#(
    parameter int unsigned N_SRC = SRC_N,
    parameter int unsigned IW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_sel,
    input  logic [N_SRC-1:0] wr_enable,
    input  logic [N_SRC-1:0] wr_clear,
    input  logic [N_SRC-1:0] active,
    output logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] cause_q,
    output logic             irq,
    output logic [IW-1:0]    idx
);

    typedef struct packed {
        logic [N_SRC-1:0] pend;
        logic [N_SRC-1:0] en;
    } line_state_t;

    line_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend | (active & st_q.en);
        if (wr_sel) begin
            st_d.en   = wr_enable;
            st_d.pend = st_d.pend & ~wr_clear;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        idx = '1;
        for (int i = 0; i < N_SRC; i++) begin
            if (st_q.pend[i]) idx = IW'(i);
        end
    end

    assign en_q    = st_q.en;
    assign cause_q = st_q.pend;
    assign irq     = |st_q.pend;

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int unsigned N_SRC  = SRC_N,
    parameter int unsigned N_LINE = LINE_N,
    parameter int unsigned AW     = ADDR_W,
    parameter int unsigned DW     = REG_W,
    parameter int unsigned IW     = IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 bus_we,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [N_SRC-1:0]     src_in,
    output logic [N_LINE-1:0]    irq_out,
    output logic [N_LINE*IW-1:0] top_idx
);

    localparam logic [AW-1:0] CFG_A = AW'(CFG_ADDR);

    logic [N_SRC-1:0]              level_q;
    logic [N_SRC-1:0]              active;
    logic [N_LINE-1:0][N_SRC-1:0]  en_all;
    logic [N_LINE-1:0][N_SRC-1:0]  cause_all;
    logic [N_LINE*N_SRC-1:0]       cause_flat;
    logic [N_LINE*N_SRC-1:0]       en_flat;
    logic [N_LINE-1:0]             line_sel;

    always_ff @(posedge clk) begin
        if (rst)                               level_q <= '0;
        else if (bus_we && bus_addr == CFG_A)  level_q <= bus_wdata[N_SRC-1:0];
    end

    irq_src_cond #(.N_SRC(N_SRC)) u_cond (
        .clk       (clk),
        .rst       (rst),
        .src_raw   (src_in),
        .level_cfg (level_q),
        .active    (active)
    );

    for (genvar n = 0; n < N_LINE; n++) begin : g_line
        localparam logic [AW-1:0] LINE_A = AW'(LINE_BASE + LINE_STEP * n);
        assign line_sel[n] = bus_we && (bus_addr == LINE_A);

        irq_line_unit #(.N_SRC(N_SRC), .IW(IW)) u_line (
            .clk       (clk),
            .rst       (rst),
            .wr_sel    (line_sel[n]),
            .wr_enable (bus_wdata[N_SRC-1:0]),
            .wr_clear  (bus_wdata[CAUSE_LSB +: N_SRC]),
            .active    (active),
            .en_q      (en_all[n]),
            .cause_q   (cause_all[n]),
            .irq       (irq_out[n]),
            .idx       (top_idx[n*IW +: IW])
        );

        assign cause_flat[n*N_SRC +: N_SRC] = cause_all[n];
        assign en_flat[n*N_SRC +: N_SRC]    = en_all[n];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CFG_A) bus_rdata[N_SRC-1:0] = level_q;
        for (int n = 0; n < N_LINE; n++) begin
            if (bus_addr == AW'(LINE_BASE + LINE_STEP * n)) begin
                bus_rdata[N_SRC-1:0]          = en_all[n];
                bus_rdata[CAUSE_LSB +: N_SRC] = cause_all[n];
            end
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter int unsigned N_SRC  = SRC_N,
    parameter int unsigned N_LINE = LINE_N,
    parameter int unsigned AW     = ADDR_W,
    parameter int unsigned DW     = REG_W,
    parameter int unsigned IW     = IDX_W
) (
    input logic                    clk,
    input logic                    rst,
    input logic [AW-1:0]           bus_addr,
    input logic                    bus_we,
    input logic [DW-1:0]           bus_wdata,
    input logic [N_LINE-1:0]       irq_out,
    input logic [N_LINE*IW-1:0]    top_idx,
    input logic [N_LINE*N_SRC-1:0] cause_flat,
    input logic [N_LINE*N_SRC-1:0] en_flat
);

    // R1: reset leaves every request line low
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (irq_out == '0));

    for (genvar n = 0; n < N_LINE; n++) begin : g_ln
        localparam logic [AW-1:0] LA = AW'(LINE_BASE + LINE_STEP * n);

        // R7/R8: request line agrees with the index output
        p_line_vs_idx_r8: assert property (@(posedge clk) disable iff (rst)
            irq_out[n] == (top_idx[n*IW +: IW] != '1));

        // R8: a reported index always names a pending source
        p_idx_pending_r8: assert property (@(posedge clk) disable iff (rst)
            (top_idx[n*IW +: IW] != '1) |-> cause_flat[n*N_SRC + int'(top_idx[n*IW +: IW])]);

        for (genvar k = 0; k < N_SRC; k++) begin : g_sk
            // R6: a W1C write leaves the flag clear after the edge
            p_w1c_clears_r6: assert property (@(posedge clk) disable iff (rst)
                (bus_we && bus_addr == LA && bus_wdata[CAUSE_LSB + k])
                |=> !cause_flat[n*N_SRC + k]);

            // R9: a disabled, clear flag cannot set
            p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
                (!cause_flat[n*N_SRC + k] && !en_flat[n*N_SRC + k])
                |=> !cause_flat[n*N_SRC + k]);
        end
    end

endmodule

bind irq_route_ctrl irq_route_chk #(
    .N_SRC(N_SRC), .N_LINE(N_LINE), .AW(AW), .DW(DW), .IW(IW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .irq_out    (irq_out),
    .top_idx    (top_idx),
    .cause_flat (cause_flat),
    .en_flat    (en_flat)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0]  src_in = 9'h004;
    logic [2:0]  irq_out;
    logic [11:0] top_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_route_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .irq_out(irq_out), .top_idx(top_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [3:0] top_of(input logic [8:0] v);
        logic [3:0] r = 4'hF;
        for (int i = 0; i < 9; i++) if (v[i]) r = 4'(i);
        return r;
    endfunction

    initial begin
        #1500000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        edges(4);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a += 4) begin
            rd(8'(a), d); check("R1 reg", d, 0);
        end
        check("R1 irq", 32'(irq_out), 0);
        check("R1 idx", 32'(top_idx), 32'hFFF);

        // R2 map and reserved bits (all sources inactive: level all high, src2 high)
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R2 level word", d, 32'h0000_01FF);
        edges(3);
        wr(8'h04, 32'hFE00_FF55);
        rd(8'h04, d); check("R2 line0 enables", d, 32'h0000_0155);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); check("R2 unmapped read", d, 0);
        rd(8'h00, d); check("R2 unmapped write ignored", d, 32'h0000_01FF);
        rd(8'h08, d); check("R2 line1 untouched", d, 0);
        wr(8'h04, 32'h01FF_0000);

        // R3/R4 polarity sweep
        for (int k = 0; k < 9; k++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int lvl = 0; lvl < 2; lvl++) begin
                    logic exp_act;
                    int ln;
                    ln = k % 3;
                    @(negedge clk);
                    src_in = 9'h004;
                    src_in[k] = lvl[0];
                    wr(8'h00, pol[0] ? 32'h1FF : 32'h0);
                    wr(8'(4 + 4*ln), 32'h01FF_0000 | (32'h1 << k));
                    edges(3);
                    wr(8'(4 + 4*ln), 32'h01FF_0000 | (32'h1 << k));
                    edges(1);
                    if (k == 1 || k == 8)  exp_act = lvl[0];
                    else if (k == 2)       exp_act = ~lvl[0];
                    else                   exp_act = (lvl[0] == pol[0]);
                    rd(8'(4 + 4*ln), d);
                    if (k == 1 || k == 2 || k == 8)
                        check("R4 fixed level", d, (32'(exp_act) << (16+k)) | (32'h1 << k));
                    else
                        check("R3 programmable level", d, (32'(exp_act) << (16+k)) | (32'h1 << k));
                    check("R7 line follows flag", 32'(irq_out), 32'(exp_act) << ln);
                    wr(8'(4 + 4*ln), 32'h01FF_0000);
                end
            end
        end

        // R5 latency
        wr(8'h00, 32'h1FF);
        @(negedge clk); src_in = 9'h004;
        edges(3);
        wr(8'h08, 32'h01FF_0020);
        src_in[5] = 1'b1;
        edges(1); check("R5 edge1 low", 32'(irq_out[1]), 0);
        edges(1); check("R5 edge2 low", 32'(irq_out[1]), 0);
        edges(1); check("R5 edge3 high", 32'(irq_out[1]), 1);
        check("R5 idx line1", 32'(top_idx[7:4]), 5);

        // R6 write-0 keeps, write-1 clears, re-set while active
        wr(8'h08, 32'h0000_0020);
        rd(8'h08, d); check("R6 write0 keeps", d, 32'h0020_0020);
        wr(8'h08, 32'h0020_0020);
        rd(8'h08, d); check("R6 clear on write edge", d, 32'h0000_0020);
        edges(1);
        rd(8'h08, d); check("R6 re-set next edge", d, 32'h0020_0020);
        src_in[5] = 1'b0;
        edges(3);
        wr(8'h08, 32'h0020_0020);
        edges(2);
        rd(8'h08, d); check("R6 stays clear when inactive", d, 32'h0000_0020);
        check("R6 line low", 32'(irq_out), 0);
        wr(8'h08, 32'h01FF_0000);

        // R9 routing independence
        wr(8'h04, 32'h01FF_0010);
        wr(8'h0C, 32'h01FF_0040);
        @(negedge clk); src_in = 9'h004 | 9'h010 | 9'h040 | 9'h080;
        edges(3);
        wr(8'h04, 32'h01FF_0010);
        wr(8'h0C, 32'h01FF_0040);
        edges(1);
        rd(8'h04, d); check("R9 line0 only src4", d, 32'h0010_0010);
        rd(8'h08, d); check("R9 line1 disabled", d, 0);
        rd(8'h0C, d); check("R9 line2 only src6", d, 32'h0040_0040);
        check("R9 lines", 32'(irq_out), 3'b101);
        check("R8 idx per line", 32'(top_idx), 32'h6F4);

        // R10 init value clears and disables
        wr(8'h04, 32'h01FF_0000);
        wr(8'h0C, 32'h01FF_0000);
        rd(8'h04, d); check("R10 line0 cleared", d, 0);
        rd(8'h0C, d); check("R10 line2 cleared", d, 0);
        edges(4);
        check("R10 lines stay low", 32'(irq_out), 0);
        check("R10 idx none", 32'(top_idx), 32'hFFF);

        // R8 exhaustive priority sweep on line 2
        wr(8'h00, 32'h1FF);
        wr(8'h0C, 32'h01FF_01FF);
        for (int v = 0; v < 512; v++) begin
            @(negedge clk); src_in = 9'(v) ^ 9'h004;
            edges(3);
            wr(8'h0C, 32'h01FF_01FF);
            edges(1);
            rd(8'h0C, d);
            check("R8 pending pattern", d, (32'(v) << 16) | 32'h1FF);
            check("R8 highest index", 32'(top_idx[11:8]), 32'(top_of(9'(v))));
            check("R7 line2 request", 32'(irq_out), (v != 0) ? 32'h4 : 32'h0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule